// File: doc/BRIEF.md
# Clock Output Power-Down Gating Controller

This block sits between the internal PLL of a clock fan-out device and its differential output drivers. A single pin carries two meanings: until it goes high for the first time after reset it is a power-good indication, and its first rising edge latches the configuration straps (a frequency select and a bus address select). From then on the same pin is an active-low power-down request that may change at any moment. It is not related to any clock.

The pin is synchronised into the output clock domain. A power-down request is honoured only when the synchronised level reads low on two rising edges in a row. The output gates then close on the next falling edge of the clock, so no output is left with a shortened high pulse. The PLL-on signal is withdrawn only once every gate is seen closed. On release the PLL is switched on first. The gates reopen on a falling edge after a programmable lock-wait count. A per-output enable bit, which comes from a register file outside this block, holds one differential pair low/low. The feedback pair keeps running while that bit is low. The enable bits are synchronised in the same way and applied only on falling edges.

Top module: `clkout_pwrdn_ctrl`

## Requirements
- R1: While `rst` is high and on the first rising edge after it: every differential pair and the feedback pair read low/low, `pll_on_o` is 0 and both strap outputs are 0.
- R2: The first rising edge of `pg_pd_n` after reset captures `strap_fs_i` and `strap_sa_i`. They appear on `strap_fs_o`/`strap_sa_o` by the 3rd rising clock edge after the pin change. Later rises of the pin never recapture them. A reset re-arms the capture.
- R3: When the pin goes high (first power-good, or release of a power-down), count as edge 1 the first rising clock edge after the change. `pll_on_o` is 0 after edge 2 and 1 after edge 3. The output gates open on the falling edge that follows edge 3+LOCK_CYC.
- R4: A low level on the pin that is seen by only one rising clock edge has no effect: the outputs keep running and `pll_on_o` stays 1.
- R5: When the pin goes low while the outputs run, count as edge 1 the first rising edge after the change. The high phase after edge 4 is the last full output pulse. From the falling edge after edge 4, every differential pair and the feedback pair read low/low.
- R6: `pll_on_o` is still 1 after edge 4 of a power-down and is 0 after edge 5. It never falls while any output gate is open.
- R7: With power-down released and `en_i[i]` = 0, pair i is held low/low while the feedback pair runs and `pll_on_o` stays 1.
- R8: With power-down released and `en_i[i]` = 1, `dif_p_o[i]` follows the clock and `dif_n_o[i]` its inverse.
- R9: A change of `en_i[i]`, with edge 1 the first rising edge after it, takes effect on the falling edge after edge 2. The high phase after edge 2 is still a full pulse with the old setting.
- R10: While powered down, all pairs and the feedback pair read low/low and `pll_on_o` is 0, whatever `en_i` does.
- R11: A power-down request qualified during the lock wait returns to the off state without the gates ever opening. `pll_on_o` is 0 after edge 4 of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Running output clock from the PLL; the gated source of every pair |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_n | input | 1 | Power-good, then active-low power-down request; asynchronous |
| en_i | input | N_OUT | Per-output enable bits from the register file; asynchronous |
| strap_fs_i | input | FS_W | Frequency-select strap level |
| strap_sa_i | input | SA_W | Address-select strap level |
| dif_p_o | output | N_OUT | True side of each differential output |
| dif_n_o | output | N_OUT | Complement side of each differential output |
| fb_p_o | output | 1 | True side of the feedback output |
| fb_n_o | output | 1 | Complement side of the feedback output |
| pll_on_o | output | 1 | PLL/VCO power-on request |
| strap_fs_o | output | FS_W | Latched frequency-select strap |
| strap_sa_o | output | SA_W | Latched address-select strap |

## Verification
Two functions can land on the same falling edge: the gating of a single output after its enable bit changes, and the global gating after a power-down request qualifies. The bench drives the enable change and the power-down in the same half-cycle. It then checks edge by edge that the single output closes first (edge 2) and that the rest close after edge 4. It also checks that an enable bit raised while powered down is honoured only when the gates reopen after the lock wait. A second overlap occurs when a new request arrives during the lock wait. It is judged by requiring that no high-phase sample ever shows an open gate and that the PLL request drops on edge 4.

// File: rtl/clkout_pwrdn_pkg.sv
package clkout_pwrdn_pkg;

  // Power sequencing states, run in the rising-edge domain of the output clock
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,  // waiting for the first power-good rise
    ST_LOCK  = 3'd1,  // PLL on, waiting for lock before opening gates
    ST_RUN   = 3'd2,  // gates open (subject to per-output enables)
    ST_DRAIN = 3'd3,  // gates commanded shut, waiting to see them closed
    ST_OFF   = 3'd4   // gates shut and PLL off
  } seq_state_e;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2   // must be at least 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import clkout_pwrdn_pkg::*;
#(
  parameter int FS_W     = 2,
  parameter int SA_W     = 2,
  parameter int LOCK_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_sync_i,   // synchronised power-good / power-down level
  input  logic            gates_off_i,  // every gate flop closed (falling-edge domain)
  input  logic [FS_W-1:0] strap_fs_i,
  input  logic [SA_W-1:0] strap_sa_i,
  output logic            master_en_o,
  output logic            pll_on_o,
  output logic [FS_W-1:0] strap_fs_o,
  output logic [SA_W-1:0] strap_sa_o
);

  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          low_q;      // synchronised level was low on the previous edge
  logic          armed_q;    // straps already captured
  logic          rise;
  logic          qual_low;

  // Rise: high now, low on the previous edge. Qualified low: low on two edges in a row.
  assign rise     = pin_sync_i & low_q;
  assign qual_low = ~pin_sync_i & low_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:  if (rise) state_d = ST_LOCK;
      ST_LOCK: begin
        if (qual_low)                state_d = ST_OFF;
        else if (cnt_q == LOCK_LAST) state_d = ST_RUN;
      end
      ST_RUN:   if (qual_low)    state_d = ST_DRAIN;
      ST_DRAIN: if (gates_off_i) state_d = ST_OFF;
      ST_OFF:   if (pin_sync_i)  state_d = ST_LOCK;
      default:  state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_INIT;
      cnt_q       <= '0;
      low_q       <= 1'b1;
      armed_q     <= 1'b0;
      strap_fs_o  <= '0;
      strap_sa_o  <= '0;
      master_en_o <= 1'b0;
      pll_on_o    <= 1'b0;
    end else begin
      state_q     <= state_d;
      low_q       <= ~pin_sync_i;
      cnt_q       <= (state_q == ST_LOCK && state_d == ST_LOCK) ? cnt_q + 1'b1 : '0;
      master_en_o <= (state_d == ST_RUN);
      pll_on_o    <= (state_d == ST_LOCK) || (state_d == ST_RUN) || (state_d == ST_DRAIN);
      if (state_q == ST_INIT && rise) begin
        armed_q    <= 1'b1;
        strap_fs_o <= strap_fs_i;
        strap_sa_o <= strap_sa_i;
      end
    end
  end

  // R6: the PLL request only drops once the falling-edge gates report closed
  a_r6_pll_off_after_gates: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_on_o) |-> gates_off_i);

  // R2: once captured, the straps never move until reset
  a_r2_straps_hold: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(armed_q)) |-> ($stable(strap_fs_o) && $stable(strap_sa_o)));

  // R4: the gate command is withdrawn only after two consecutive low samples
  a_r4_qualified_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(master_en_o) |-> (!$past(pin_sync_i) && !$past(pin_sync_i, 2)));

  // R1: the edge after a reset leaves the PLL request off
  a_r1_reset_pll_off: assert property (@(posedge clk)
    $past(rst) |-> !pll_on_o);

endmodule

// File: rtl/out_gate_bank.sv
module out_gate_bank #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en_i,
  input  logic [N_OUT-1:0] en_sync_i,
  output logic [N_OUT-1:0] dif_p_o,
  output logic [N_OUT-1:0] dif_n_o,
  output logic             fb_p_o,
  output logic             fb_n_o,
  output logic             gates_off_o
);

  logic [N_OUT-1:0] gate_q;
  logic             fb_gate_q;

  // Gate flops change only while the clock is low, so no pulse is cut short
  always_ff @(negedge clk) begin
    if (rst) begin
      gate_q    <= '0;
      fb_gate_q <= 1'b0;
    end else begin
      gate_q    <= en_sync_i & {N_OUT{master_en_i}};
      fb_gate_q <= master_en_i;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_pair
    assign dif_p_o[g] = clk & gate_q[g];
    assign dif_n_o[g] = ~clk & gate_q[g];
  end

  assign fb_p_o      = clk & fb_gate_q;
  assign fb_n_o      = ~clk & fb_gate_q;
  assign gates_off_o = ~(|gate_q) & ~fb_gate_q;

  // R10: with the master command low through a cycle, no gate is open
  a_r10_gated_when_down: assert property (@(posedge clk) disable iff (rst)
    !master_en_i |-> (gate_q == '0 && !fb_gate_q));

  // R7: the feedback gate follows the master command regardless of enables
  a_r7_fb_runs: assert property (@(posedge clk) disable iff (rst)
    (master_en_i && $past(master_en_i)) |-> fb_gate_q);

endmodule

// File: rtl/clkout_pwrdn_ctrl.sv
module clkout_pwrdn_ctrl #(
  parameter int N_OUT       = 4,
  parameter int FS_W        = 2,
  parameter int SA_W        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYC    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pg_pd_n,
  input  logic [N_OUT-1:0] en_i,
  input  logic [FS_W-1:0]  strap_fs_i,
  input  logic [SA_W-1:0]  strap_sa_i,
  output logic [N_OUT-1:0] dif_p_o,
  output logic [N_OUT-1:0] dif_n_o,
  output logic             fb_p_o,
  output logic             fb_n_o,
  output logic             pll_on_o,
  output logic [FS_W-1:0]  strap_fs_o,
  output logic [SA_W-1:0]  strap_sa_o
);

  logic             pin_sync;
  logic [N_OUT-1:0] en_sync;
  logic             master_en;
  logic             gates_off;

  bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk (clk), .rst (rst), .d_i (pg_pd_n), .q_o (pin_sync)
  );

  bit_sync #(.WIDTH(N_OUT), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk (clk), .rst (rst), .d_i (en_i), .q_o (en_sync)
  );

  pd_sequencer #(.FS_W(FS_W), .SA_W(SA_W), .LOCK_CYC(LOCK_CYC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .pin_sync_i  (pin_sync),
    .gates_off_i (gates_off),
    .strap_fs_i  (strap_fs_i),
    .strap_sa_i  (strap_sa_i),
    .master_en_o (master_en),
    .pll_on_o    (pll_on_o),
    .strap_fs_o  (strap_fs_o),
    .strap_sa_o  (strap_sa_o)
  );

  out_gate_bank #(.N_OUT(N_OUT)) u_gates (
    .clk         (clk),
    .rst         (rst),
    .master_en_i (master_en),
    .en_sync_i   (en_sync),
    .dif_p_o     (dif_p_o),
    .dif_n_o     (dif_n_o),
    .fb_p_o      (fb_p_o),
    .fb_n_o      (fb_n_o),
    .gates_off_o (gates_off)
  );

endmodule

// File: tb/clkout_pwrdn_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkout_pwrdn_ctrl_tb_top;

  localparam int N  = 4;
  localparam int FW = 2;
  localparam int SW = 2;
  localparam int L  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pg = 1'b0;
  logic [N-1:0]  en = '1;
  logic [FW-1:0] fs = 2'b10;
  logic [SW-1:0] sa = 2'b01;
  logic [N-1:0]  dif_p, dif_n;
  logic          fb_p, fb_n, pll_on;
  logic [FW-1:0] fs_o;
  logic [SW-1:0] sa_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  clkout_pwrdn_ctrl #(.N_OUT(N), .FS_W(FW), .SA_W(SW), .SYNC_STAGES(2), .LOCK_CYC(L)) dut_i (
    .clk (clk), .rst (rst), .pg_pd_n (pg), .en_i (en),
    .strap_fs_i (fs), .strap_sa_i (sa),
    .dif_p_o (dif_p), .dif_n_o (dif_n), .fb_p_o (fb_p), .fb_n_o (fb_n),
    .pll_on_o (pll_on), .strap_fs_o (fs_o), .strap_sa_o (sa_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step();   // sample in the high phase after a rising edge
    @(posedge clk); #2;
  endtask

  task automatic at_fall(); // drive just after a falling edge
    @(negedge clk); #1;
  endtask

  // Rising of the pin: PLL on after edge 3, gates open after edge 3+L
  task automatic rise_seq(string tag, int exp_fs, int exp_sa, int exp_en);
    at_fall(); pg = 1'b1;
    for (int k = 1; k <= L + 4; k++) begin
      step();
      if (k == 2) chk({tag, " R3 pll still off"}, int'(pll_on), 0);
      if (k == 3) begin
        chk({tag, " R3 pll on"}, int'(pll_on), 1);
        chk({tag, " R2 fs strap"}, int'(fs_o), exp_fs);
        chk({tag, " R2 sa strap"}, int'(sa_o), exp_sa);
      end
      if (k == L + 3) chk({tag, " R3 gates still shut"}, int'(dif_p), 0);
      if (k == L + 4) begin
        chk({tag, " R8 dif_p running"}, int'(dif_p), exp_en);
        chk({tag, " R8 fb_p running"}, int'(fb_p), 1);
        #4;
        chk({tag, " R8 dif_n running"}, int'(dif_n), exp_en);
        chk({tag, " R8 dif_p low phase"}, int'(dif_p), 0);
      end
    end
  endtask

  task automatic t_reset();
    repeat (4) step();
    chk("R1 pll", int'(pll_on), 0);
    chk("R1 dif_p", int'(dif_p), 0);
    chk("R1 fb_p", int'(fb_p), 0);
    chk("R1 straps", int'({fs_o, sa_o}), 0);
    #4;
    chk("R1 dif_n", int'(dif_n), 0);
    chk("R1 fb_n", int'(fb_n), 0);
    at_fall(); rst = 1'b0;
  endtask

  task automatic t_enable();
    at_fall(); en = 4'b1101;
    for (int k = 1; k <= 3; k++) begin
      step();
      if (k == 2) begin
        chk("R9 old setting early high", int'(dif_p), 4'hF);
        #1;
        chk("R9 old setting late high", int'(dif_p), 4'hF);
      end
      if (k == 3) begin
        chk("R9 new setting", int'(dif_p), 4'hD);
        chk("R7 fb runs", int'(fb_p), 1);
        chk("R7 pll stays on", int'(pll_on), 1);
        #4;
        chk("R7 dif_n held", int'(dif_n), 4'hD);
        chk("R7 fb_n runs", int'(fb_n), 1);
      end
    end
    at_fall(); en = 4'hF;
    repeat (3) step();
    chk("R8 re-enabled", int'(dif_p), 4'hF);
  endtask

  task automatic t_glitch();
    at_fall(); pg = 1'b0;
    at_fall(); pg = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R4 short low ignored", int'({pll_on, dif_p}), 5'h1F);
    end
  endtask

  task automatic t_pwrdn();
    at_fall(); pg = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      step();
      if (k == 4) begin
        chk("R5 last full pulse", int'(dif_p), 4'hF);
        chk("R6 pll on at edge 4", int'(pll_on), 1);
      end
      if (k == 5) begin
        chk("R5 dif_p gated", int'(dif_p), 0);
        chk("R5 fb_p gated", int'(fb_p), 0);
        chk("R6 pll off at edge 5", int'(pll_on), 0);
        #4;
        chk("R10 dif_n gated", int'(dif_n), 0);
        chk("R10 fb_n gated", int'(fb_n), 0);
      end
    end
    at_fall(); en = 4'b0011;
    repeat (4) step();
    chk("R10 enables ignored", int'({pll_on, fb_p, dif_p}), 0);
    at_fall(); en = 4'hF;
  endtask

  task automatic t_same_edge();
    at_fall(); pg = 1'b0; en = 4'b1110;
    for (int k = 1; k <= 5; k++) begin
      step();
      if (k == 3) chk("R9 single gate first", int'(dif_p), 4'hE);
      if (k == 5) chk("R5 all gated after", int'(dif_p), 0);
    end
    at_fall(); en = 4'hF;
    repeat (2) step();
    chk("R10 enable while down", int'(dif_p), 0);
    rise_seq("same-edge release", 2, 1, 4'hF);
  endtask

  task automatic t_lock_abort();
    bit opened = 0;
    at_fall(); pg = 1'b0;
    repeat (6) step();
    at_fall(); pg = 1'b1;
    repeat (3) step();
    chk("R11 pll on in lock wait", int'(pll_on), 1);
    at_fall(); pg = 1'b0;
    for (int j = 1; j <= L + 6; j++) begin
      step();
      if (dif_p != 0 || fb_p) opened = 1;
      if (j == 4) chk("R11 pll off at edge 4", int'(pll_on), 0);
    end
    chk("R11 gates never opened", int'(opened), 0);
  endtask

  task automatic t_rearm();
    fs = 2'b11; sa = 2'b11; pg = 1'b1;
    at_fall(); rst = 1'b1;
    repeat (2) step();
    chk("R1 straps cleared", int'({fs_o, sa_o}), 0);
    at_fall(); rst = 1'b0;
    repeat (L + 6) step();
    chk("R2 recapture fs", int'(fs_o), 3);
    chk("R2 recapture sa", int'(sa_o), 3);
    chk("R3 running after rearm", int'(dif_p), 4'hF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    rise_seq("power-up", 2, 1, 4'hF);
    t_enable();
    t_glitch();
    t_pwrdn();
    fs = 2'b01; sa = 2'b10;   // new straps must not be taken on release
    rise_seq("release", 2, 1, 4'hF);
    t_same_edge();
    t_lock_abort();
    t_rearm();
    finish_run();
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule